// File: doc/BRIEF.md
# Prioritized Event Interrupt Controller with Power-Down Wake

This block gathers fifteen maskable event interrupt sources into sticky pending flags and picks one winner for the CPU by programmable priority. Eleven slots are fed by hardware request lines. The top four slots have no hardware input at all: software raises them by writing to a set register, so they act as high-priority software interrupts. Each slot has an enable bit and a 4-bit priority, where priority zero takes the slot out of the contest. The winner's index is offered to the CPU only while its priority is strictly above the CPU's current 4-bit mask level.

The request output is a plain level, not a valid/ready stream. It stays high for as long as the winning condition holds. The CPU never acknowledges it and cannot stall it, and the block applies no back-pressure. A pending flag is removed only by a write of one to the clear register. A second output, the wake signal, ends power-down mode. It is purely combinational from the raw pins and the stored configuration, so it works with the oscillator stopped. It is raised by reset or by either of the two external interrupt lines.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While rst_n is low, wake is high and irq_req is low; after reset all flags, enables and priorities are zero.
- R2: A hardware line i (0..10) that is high at a rising clock edge sets flag i. The flag stays set until a write to address 0 with data bit i = 1. If a set and a clear of the same flag land on the same edge, the set wins.
- R3: Flags 11..14 are set only by a write to address 1 with data bit i = 1. Ones written at bit positions 0..10 of address 1 have no effect.
- R4: Address 2 bit i enables source i. A disabled pending source raises no request, but its flag is kept and it requests again once re-enabled.
- R5: The priority of source i is written at address 3 + i/4, in data bits [4*(i%4)+3 : 4*(i%4)]. A source with priority 0 never requests.
- R6: Among pending, enabled sources with nonzero priority, the highest priority wins. On a tie, the lowest index wins.
- R7: irq_req is high exactly when the winner's priority is strictly greater than cpu_mask. irq_vec then carries the winner's index; otherwise irq_vec is 0.
- R8: wake is high when line 0 (or line 1) is high, that source is enabled, and its priority is strictly greater than cpu_mask. It responds to pin changes without any clock edge.
- R9: With rst_n high, hardware lines 2..10 and all flags have no effect on wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also a wake cause |
| hw_req | input | 11 | Hardware event request lines; bits 0 and 1 are the external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 clear, 1 software set, 2 enable, 3..6 priorities |
| wr_data | input | 16 | Register write data |
| cpu_mask | input | 4 | Current CPU mask level |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 4 | Index of the winning source |
| wake | output | 1 | Power-down exit request |

## Verification
The bench uses the default parameters: fifteen sources, four of them software-only, 4-bit priorities, and the external pins on lines 0 and 1. With these values every mask level from 0 to 15 can be driven, so the strict-greater comparison is tested at equality on both the request and the wake path. Full-width priority fields make ties between neighbouring and distant indices reachable. Random writes over all eight addresses also reach the unused address and the hardware bit positions of the software set register.

// File: rtl/eic_pkg.sv
package eic_pkg;
  // register offsets; the priority bank starts at REG_PRIO0 and is contiguous
  localparam int unsigned REG_CLR   = 0;
  localparam int unsigned REG_SET   = 1;
  localparam int unsigned REG_EN    = 2;
  localparam int unsigned REG_PRIO0 = 3;
endpackage

// File: rtl/eic_flag_bank.sv
module eic_flag_bank #(
  parameter int NUM_SRC = 15,
  parameter int NUM_SW  = 4,
  localparam int NUM_HW = NUM_SRC - NUM_SW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_HW-1:0]  hw_req,
  input  logic [NUM_SRC-1:0] clr_vec,
  input  logic [NUM_SW-1:0]  set_sw,
  output logic [NUM_SRC-1:0] flags_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic raise;
    if (i < NUM_HW) begin : g_hw
      assign raise = hw_req[i];
    end else begin : g_sw
      assign raise = set_sw[i-NUM_HW];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= (flags_q[i] & ~clr_vec[i]) | raise;
    end
  end
endmodule

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs
  import eic_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  localparam int PER_REG = DATA_W / PRIO_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_SRC-1:0]        en_q,
  output logic [NUM_SRC*PRIO_W-1:0] prio_q
);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(REG_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       en_q <= '0;
    else if (wr_en && wr_addr == A_EN) en_q <= wr_data[NUM_SRC-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    localparam int FLD = i % PER_REG;
    localparam logic [ADDR_W-1:0] A_P = ADDR_W'(REG_PRIO0 + i / PER_REG);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[i*PRIO_W +: PRIO_W] <= '0;
      else if (wr_en && wr_addr == A_P)
        prio_q[i*PRIO_W +: PRIO_W] <= wr_data[FLD*PRIO_W +: PRIO_W];
    end
  end
endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter #(
  parameter int NUM_SRC = 15,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0]         win_prio,
  output logic [IDX_W-1:0]          win_idx
);
  // descending scan with >= lets the lower index take a tie
  always_comb begin
    win_prio = '0;
    win_idx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && prio[i*PRIO_W +: PRIO_W] >= win_prio) begin
        win_prio = prio[i*PRIO_W +: PRIO_W];
        win_idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/eic_wake.sv
module eic_wake #(
  parameter int PRIO_W  = 4,
  parameter int NUM_PIN = 2
) (
  input  logic                      rst_n,
  input  logic [NUM_PIN-1:0]        pin,
  input  logic [NUM_PIN-1:0]        pin_en,
  input  logic [NUM_PIN*PRIO_W-1:0] pin_prio,
  input  logic [PRIO_W-1:0]         mask,
  output logic                      wake
);
  logic [NUM_PIN-1:0] hit;
  for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
    assign hit[k] = pin[k] & pin_en[k] & (pin_prio[k*PRIO_W +: PRIO_W] > mask);
  end
  assign wake = ~rst_n | (|hit);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_SRC  = 15,
  parameter int NUM_SW   = 4,
  parameter int PRIO_W   = 4,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 16,
  parameter int EXT0_IDX = 0,
  parameter int EXT1_IDX = 1,
  localparam int NUM_HW  = NUM_SRC - NUM_SW,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PRIO_W-1:0] cpu_mask,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_vec,
  output logic              wake
);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(REG_CLR);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(REG_SET);

  logic [NUM_SRC-1:0]        clr_vec, flags_q, en_q, cand_w;
  logic [NUM_SW-1:0]         set_sw;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]         win_prio;
  logic [IDX_W-1:0]          win_idx;

  assign clr_vec = (wr_en && wr_addr == A_CLR) ? wr_data[NUM_SRC-1:0] : '0;
  assign set_sw  = (wr_en && wr_addr == A_SET) ? wr_data[NUM_SRC-1:NUM_HW] : '0;

  eic_flag_bank #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW)) flags_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
    .clr_vec(clr_vec), .set_sw(set_sw), .flags_q(flags_q)
  );

  eic_cfg_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_q(en_q), .prio_q(prio_q)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cand
    assign cand_w[i] = flags_q[i] & en_q[i] & (|prio_q[i*PRIO_W +: PRIO_W]);
  end

  eic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
    .cand(cand_w), .prio(prio_q), .win_prio(win_prio), .win_idx(win_idx)
  );

  assign irq_req = win_prio > cpu_mask;
  assign irq_vec = irq_req ? win_idx : '0;

  eic_wake #(.PRIO_W(PRIO_W), .NUM_PIN(2)) wake_i (
    .rst_n(rst_n),
    .pin({hw_req[EXT1_IDX], hw_req[EXT0_IDX]}),
    .pin_en({en_q[EXT1_IDX], en_q[EXT0_IDX]}),
    .pin_prio({prio_q[EXT1_IDX*PRIO_W +: PRIO_W], prio_q[EXT0_IDX*PRIO_W +: PRIO_W]}),
    .mask(cpu_mask),
    .wake(wake)
  );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int NUM_SRC = 15,
  parameter int NUM_SW  = 4,
  parameter int PRIO_W  = 4,
  localparam int NUM_HW = NUM_SRC - NUM_SW,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ext0,
  input logic                      ext1,
  input logic [PRIO_W-1:0]         cpu_mask,
  input logic                      irq_req,
  input logic [IDX_W-1:0]          irq_vec,
  input logic                      wake,
  input logic [NUM_SRC-1:0]        flags,
  input logic [NUM_SRC-1:0]        clr,
  input logic [NUM_SW-1:0]         set_sw,
  input logic [NUM_SRC-1:0]        cand,
  input logic [NUM_SRC*PRIO_W-1:0] prio
);
  always_comb begin
    if (!rst_n) p_wake_in_reset_r1: assert (wake);
    if (rst_n && !ext0 && !ext1) p_no_stray_wake_r9: assert (!wake);
  end

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == '0));

  p_sw_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags[NUM_SRC-1:NUM_HW] & ~$past(flags[NUM_SRC-1:NUM_HW]) & ~$past(set_sw)) == '0));

  p_vec_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> cand[irq_vec]);

  p_above_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (prio[irq_vec*PRIO_W +: PRIO_W] > cpu_mask));

  p_idle_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == '0));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW), .PRIO_W(PRIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ext0(hw_req[EXT0_IDX]), .ext1(hw_req[EXT1_IDX]),
  .cpu_mask(cpu_mask), .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake),
  .flags(flags_q), .clr(clr_vec), .set_sw(set_sw), .cand(cand_w), .prio(prio_q)
);

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] hw_req = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  cpu_mask = '0;
  logic        irq_req, wake;
  logic [3:0]  irq_vec;

  int total = 0;
  int bad = 0;

  logic [14:0] m_flags = '0;
  logic [14:0] m_en = '0;
  logic [3:0]  m_prio [15];

  always #10 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_mask(cpu_mask), .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model of the register file, updated from the stimulus seen at the edge
  task automatic tick();
    @(posedge clk);
    if (wr_en && wr_addr == 3'd0) m_flags = m_flags & ~wr_data[14:0];
    m_flags = m_flags | {4'b0, hw_req};
    if (wr_en && wr_addr == 3'd1) m_flags = m_flags | {wr_data[14:11], 11'b0};
    if (wr_en && wr_addr == 3'd2) m_en = wr_data[14:0];
    if (wr_en && wr_addr >= 3'd3 && wr_addr <= 3'd6)
      for (int j = 0; j < 4; j++) begin
        int idx = (int'(wr_addr) - 3) * 4 + j;
        if (idx < 15) m_prio[idx] = wr_data[j*4 +: 4];
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
  endtask

  function automatic int exp_win_prio();
    int bp = 0;
    for (int i = 0; i < 15; i++)
      if (m_flags[i] && m_en[i] && m_prio[i] != 0 && int'(m_prio[i]) > bp) bp = int'(m_prio[i]);
    return bp;
  endfunction

  function automatic int exp_win_idx();
    int bp = 0, bi = 0;
    for (int i = 0; i < 15; i++)
      if (m_flags[i] && m_en[i] && m_prio[i] != 0 && int'(m_prio[i]) > bp) begin
        bp = int'(m_prio[i]); bi = i;
      end
    return bi;
  endfunction

  function automatic int exp_wake();
    logic w0, w1;
    w0 = hw_req[0] && m_en[0] && (m_prio[0] > cpu_mask);
    w1 = hw_req[1] && m_en[1] && (m_prio[1] > cpu_mask);
    return int'(w0 | w1);
  endfunction

  task automatic check_all(input string tag);
    int r;
    r = (exp_win_prio() > int'(cpu_mask)) ? 1 : 0;
    chk({tag, " R7 irq_req"}, int'(irq_req), r);
    chk({tag, " R6 irq_vec"}, int'(irq_vec), r ? exp_win_idx() : 0);
    chk({tag, " R8 wake"}, int'(wake), exp_wake());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 15; i++) m_prio[i] = '0;
    // R1: reset state
    hw_req = 11'h7FF;
    repeat (3) @(negedge clk);
    chk("R1 wake in reset", int'(wake), 1);
    chk("R1 no request in reset", int'(irq_req), 0);
    rst_n = 1'b1; hw_req = '0;
    #1;
    chk("R1 wake after release", int'(wake), 0);
    check_all("R1 post-reset");

    // R5: enabled, pending, but priority 0
    wr(3'd2, 16'h7FFF);
    hw_req = 11'h7FF; tick(); hw_req = '0;
    chk("R5 prio zero blocks", int'(irq_req), 0);
    // R6: tie between sources 2 and 3 at priority 3
    wr(3'd3, 16'h3300);
    chk("R6 tie lower index", int'(irq_vec), 2);
    check_all("R6");
    // R7: strict comparison against the mask
    cpu_mask = 4'd3; #1;
    chk("R7 equal mask blocks", int'(irq_req), 0);
    cpu_mask = 4'd2; #1;
    chk("R7 below mask passes", int'(irq_req), 1);
    // R2: clearing one flag, the other stays sticky
    wr(3'd0, 16'h0004);
    chk("R2 after clear vec", int'(irq_vec), 3);
    // R2: set wins over clear on the same edge
    hw_req = 11'h008; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0008; tick(); hw_req = '0;
    chk("R2 set beats clear", int'(irq_vec), 3);
    // R4: disable keeps the flag
    wr(3'd2, 16'h7FF7);
    chk("R4 disabled no request", int'(irq_req), 0);
    wr(3'd2, 16'h7FFF);
    chk("R4 re-enabled request", int'(irq_vec), 3);
    // R3: software set at hardware positions has no effect
    wr(3'd0, 16'h7FFF);
    wr(3'd1, 16'h07FF);
    chk("R3 hw bits of set ignored", int'(irq_req), 0);
    wr(3'd6, 16'h0090);
    wr(3'd1, 16'h2000);
    chk("R3 software flag 13", int'(irq_vec), 13);
    check_all("R3");
    // R8/R9: wake, clock-free
    wr(3'd0, 16'h7FFF);
    wr(3'd3, 16'h0076);
    cpu_mask = 4'd6;
    hw_req = 11'h001; #1;
    chk("R8 prio equal mask no wake", int'(wake), 0);
    hw_req = 11'h002; #1;
    chk("R8 wake without clock edge", int'(wake), 1);
    hw_req = 11'h020; #1;
    chk("R9 other line no wake", int'(wake), 0);
    hw_req = '0;
    wr(3'd2, 16'h7FFD);
    hw_req = 11'h002; #1;
    chk("R8 disabled pin no wake", int'(wake), 0);
    hw_req = '0;

    // constrained random
    for (int it = 0; it < 3000; it++) begin
      for (int b = 0; b < 11; b++) hw_req[b] = ($urandom % 8) == 0;
      cpu_mask = 4'($urandom % 16);
      wr_en    = ($urandom % 3) == 0;
      wr_addr  = 3'($urandom % 8);
      wr_data  = 16'($urandom);
      tick();
      check_all("rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule